// File: doc/BRIEF.md
# Privilege-Gated Counter CSR File

This block is a compact machine-level control and status register file for a small in-order core. It keeps the current privilege level, the identity registers, the status word and two counter-enable masks, and it answers reads of thirty-two counter slots: a free-running cycle count, a wall-clock time value supplied from outside, a retired-instruction count, and twenty-nine performance slots that all report the cycle count.

Each counter read is filtered by the privilege level held in the file. Machine mode sees every counter. Supervisor mode sees a counter only when its bit is set in the machine-level enable mask. User mode sees a counter only when its bit is set in the supervisor-level enable mask. A filtered counter reads as zero and raises no error. Writes aimed at the counter slots are silently discarded. Writes aimed at any other valid register store the data as given. Indices that name no register raise an illegal-access flag, read as zero and change nothing.

Reads are combinational from the index. Writes are taken on the rising clock edge.

Top module: `csr_ctr_file`

## Requirements
- R1: After reset, index 0 (privilege) reads 3 (machine mode), and indices 2, 3 and 4 (vendor, architecture and implementation identity) read 0.
- R2: After reset, index 1 (ISA word) reads 0x800000000014112D: value 2 in bits 63:62, extension bits 0x14112D.
- R3: After reset, index 5 (status) reads 0x0000000A00002000: bits 33:32 = 2, bits 35:34 = 2, bits 14:13 = 1, every other bit 0.
- R4: After reset, index 6 (machine counter-enable mask) and index 7 (supervisor counter-enable mask) both read 0x7.
- R5: Indices 0 to 7 are plain registers; a write (wrEn high at a rising edge) to any of them stores wrData unchanged, and the value reads back from the next cycle on.
- R6: Counter n (n = 0..31) sits at index 32 + n; when bits 1:0 of the privilege register are 3, every counter returns its live value.
- R7: When privilege bits 1:0 are 1, counter n is readable only if bit n of index 6 is set; when they are 0, only if bit n of index 7 is set; when they are 2, no counter is readable.
- R8: A read of a counter that is not readable returns 0 and leaves illegal low.
- R9: Counter 0 is a 64-bit cycle count that is 0 during reset and grows by one on every clock edge after reset; counters 3 to 31 return the same value as counter 0.
- R10: Counter 1 returns the value on timeIn.
- R11: Counter 2 is a 64-bit count that is 0 during reset and grows by one on each rising edge at which retire is high.
- R12: A write to any index from 32 to 63 changes no plain register and does not disturb any count.
- R13: Indices 8 to 31 are invalid: with rdEn or wrEn high, illegal is high and rdData is 0, and a write there changes nothing; rdData is 0 whenever rdEn is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rdEn | input | 1 | Read strobe for csrIdx |
| wrEn | input | 1 | Write strobe for csrIdx |
| csrIdx | input | 6 | Register index |
| wrData | input | 64 | Data to store |
| timeIn | input | 64 | Wall-clock time value |
| retire | input | 1 | One instruction retired this cycle |
| rdData | output | 64 | Combinational read data |
| illegal | output | 1 | Access to an index that names no register |

## Verification
The bench builds the block with its default parameters: a 6-bit index, eight plain registers and thirty-two counter slots starting at index 32. That puts every counter slot, every bit of both enable masks and the invalid hole from 8 to 31 within reach of directed reads, so the gating is checked per counter in all four privilege encodings, including the reserved one. Writes into the counter range are followed by reads of every plain register and of the live counts to show nothing moved.

// File: rtl/csr_ctr_pkg.sv
package csr_ctr_pkg;

  localparam int XLEN = 64;

  typedef enum logic [1:0] {
    PRIV_U    = 2'd0,
    PRIV_S    = 2'd1,
    PRIV_RSVD = 2'd2,
    PRIV_M    = 2'd3
  } priv_e;

  // plain register slots
  localparam int IDX_PRIV   = 0;
  localparam int IDX_ISA    = 1;
  localparam int IDX_VENDOR = 2;
  localparam int IDX_ARCH   = 3;
  localparam int IDX_IMPL   = 4;
  localparam int IDX_STATUS = 5;
  localparam int IDX_MCEN   = 6;
  localparam int IDX_SCEN   = 7;

  // counter slots, relative to the counter base
  localparam int CTR_CYCLE   = 0;
  localparam int CTR_TIME    = 1;
  localparam int CTR_INSTRET = 2;

  // field positions that give the reset words their shape
  localparam int MXL_LSB = XLEN - 2;
  localparam int UXL_LSB = 32;
  localparam int SXL_LSB = 34;
  localparam int FS_LSB  = 13;
  localparam logic [XLEN-1:0] ISA_EXT = 64'h14112D;

  typedef struct packed {
    logic rdPlain;
    logic wrPlain;
    logic rdCtr;
    logic ctrGate;
    logic badIdx;
  } csr_strobe_t;

  function automatic logic [XLEN-1:0] plainResetValue(input int slot);
    logic [XLEN-1:0] v;
    v = '0;
    case (slot)
      IDX_PRIV:   v = XLEN'(PRIV_M);
      IDX_ISA:    v = (XLEN'(2) << MXL_LSB) | ISA_EXT;
      IDX_STATUS: v = (XLEN'(2) << UXL_LSB) | (XLEN'(2) << SXL_LSB) | (XLEN'(1) << FS_LSB);
      IDX_MCEN:   v = XLEN'(7);
      IDX_SCEN:   v = XLEN'(7);
      default:    v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/csr_ctr_ctrl.sv
module csr_ctr_ctrl
  import csr_ctr_pkg::*;
#(
  parameter int IDX_W     = 6,
  parameter int NUM_PLAIN = 8,
  parameter int CTR_BASE  = 32,
  parameter int NUM_CTR   = 32,
  localparam int PLAIN_W  = $clog2(NUM_PLAIN),
  localparam int CTR_W    = $clog2(NUM_CTR)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rdEn,
  input  logic               wrEn,
  input  logic [IDX_W-1:0]   csrIdx,
  input  logic [1:0]         privBits,
  input  logic [NUM_CTR-1:0] mcen,
  input  logic [NUM_CTR-1:0] scen,
  output csr_strobe_t        strb,
  output logic [PLAIN_W-1:0] plainSel,
  output logic [CTR_W-1:0]   ctrSel
);

  localparam int XW = IDX_W + 1;
  localparam logic [XW-1:0] PLAIN_END = XW'(NUM_PLAIN);
  localparam logic [XW-1:0] CTR_LO    = XW'(CTR_BASE);
  localparam logic [XW-1:0] CTR_HI    = XW'(CTR_BASE + NUM_CTR);

  logic [XW-1:0] idxX;
  logic [XW-1:0] ctrOff;
  logic          isPlain;
  logic          isCtr;
  logic          gate;

  assign idxX    = {1'b0, csrIdx};
  assign isPlain = idxX < PLAIN_END;
  assign isCtr   = (idxX >= CTR_LO) && (idxX < CTR_HI);
  assign ctrOff  = idxX - CTR_LO;
  assign ctrSel  = ctrOff[CTR_W-1:0];
  assign plainSel = csrIdx[PLAIN_W-1:0];

  always_comb begin
    case (priv_e'(privBits))
      PRIV_M:  gate = 1'b1;
      PRIV_S:  gate = mcen[ctrSel];
      PRIV_U:  gate = scen[ctrSel];
      default: gate = 1'b0;
    endcase
  end

  always_comb begin
    strb.rdPlain = rdEn & isPlain;
    strb.wrPlain = wrEn & isPlain;
    strb.rdCtr   = rdEn & isCtr;
    strb.ctrGate = gate;
    strb.badIdx  = (rdEn | wrEn) & ~isPlain & ~isCtr;
  end

  // R13: an access is either plain, counter or invalid, never two at once
  assert_strobe_exclusive_R13: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.rdPlain | strb.wrPlain, strb.rdCtr, strb.badIdx}));

endmodule

// File: rtl/csr_ctr_dp.sv
module csr_ctr_dp
  import csr_ctr_pkg::*;
#(
  parameter int NUM_PLAIN = 8,
  parameter int NUM_CTR   = 32,
  localparam int PLAIN_W  = $clog2(NUM_PLAIN),
  localparam int CTR_W    = $clog2(NUM_CTR)
) (
  input  logic               clk,
  input  logic               rst,
  input  csr_strobe_t        strb,
  input  logic [PLAIN_W-1:0] plainSel,
  input  logic [CTR_W-1:0]   ctrSel,
  input  logic [XLEN-1:0]    wrData,
  input  logic [XLEN-1:0]    timeIn,
  input  logic               retire,
  output logic [XLEN-1:0]    rdData,
  output logic [1:0]         privBits,
  output logic [NUM_CTR-1:0] mcen,
  output logic [NUM_CTR-1:0] scen
);

  logic [NUM_PLAIN-1:0][XLEN-1:0] plainRegs;
  logic [XLEN-1:0] cycleCnt;
  logic [XLEN-1:0] instretCnt;
  logic [XLEN-1:0] ctrValue;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_PLAIN; i++) begin
      if (rst) begin
        plainRegs[i] <= plainResetValue(i);
      end else if (strb.wrPlain && (plainSel == PLAIN_W'(i))) begin
        plainRegs[i] <= wrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cycleCnt   <= '0;
      instretCnt <= '0;
    end else begin
      cycleCnt <= cycleCnt + XLEN'(1);
      if (retire) instretCnt <= instretCnt + XLEN'(1);
    end
  end

  assign privBits = plainRegs[IDX_PRIV][1:0];
  assign mcen     = plainRegs[IDX_MCEN][NUM_CTR-1:0];
  assign scen     = plainRegs[IDX_SCEN][NUM_CTR-1:0];

  always_comb begin
    case (int'(ctrSel))
      CTR_TIME:    ctrValue = timeIn;
      CTR_INSTRET: ctrValue = instretCnt;
      default:     ctrValue = cycleCnt;
    endcase
  end

  always_comb begin
    if (strb.rdPlain)                    rdData = plainRegs[plainSel];
    else if (strb.rdCtr && strb.ctrGate) rdData = ctrValue;
    else                                 rdData = '0;
  end

  // R9: cycle count advances by exactly one each clock out of reset
  assert_cycle_step_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cycleCnt == $past(cycleCnt) + XLEN'(1));

  // R11: retired count follows the retire pulse
  assert_instret_step_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(retire)) |-> instretCnt == $past(instretCnt) + XLEN'(1));

  assert_instret_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(retire)) |-> $stable(instretCnt));

  // R12: without a plain write strobe no plain register moves
  assert_plain_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(strb.wrPlain)) |-> $stable(plainRegs));

endmodule

// File: rtl/csr_ctr_file.sv
module csr_ctr_file
  import csr_ctr_pkg::*;
#(
  parameter int IDX_W     = 6,
  parameter int NUM_PLAIN = 8,
  parameter int CTR_BASE  = 32,
  parameter int NUM_CTR   = 32,
  localparam int PLAIN_W  = $clog2(NUM_PLAIN),
  localparam int CTR_W    = $clog2(NUM_CTR)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rdEn,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] csrIdx,
  input  logic [63:0]      wrData,
  input  logic [63:0]      timeIn,
  input  logic             retire,
  output logic [63:0]      rdData,
  output logic             illegal
);

  csr_strobe_t        strb;
  logic [PLAIN_W-1:0] plainSel;
  logic [CTR_W-1:0]   ctrSel;
  logic [1:0]         privBits;
  logic [NUM_CTR-1:0] mcen;
  logic [NUM_CTR-1:0] scen;

  csr_ctr_ctrl #(
    .IDX_W(IDX_W), .NUM_PLAIN(NUM_PLAIN), .CTR_BASE(CTR_BASE), .NUM_CTR(NUM_CTR)
  ) ctrl_i (
    .clk(clk), .rst(rst), .rdEn(rdEn), .wrEn(wrEn), .csrIdx(csrIdx),
    .privBits(privBits), .mcen(mcen), .scen(scen),
    .strb(strb), .plainSel(plainSel), .ctrSel(ctrSel)
  );

  csr_ctr_dp #(
    .NUM_PLAIN(NUM_PLAIN), .NUM_CTR(NUM_CTR)
  ) dp_i (
    .clk(clk), .rst(rst), .strb(strb), .plainSel(plainSel), .ctrSel(ctrSel),
    .wrData(wrData), .timeIn(timeIn), .retire(retire),
    .rdData(rdData), .privBits(privBits), .mcen(mcen), .scen(scen)
  );

  assign illegal = strb.badIdx;

  // R13: invalid accesses and idle cycles put zero on the read bus
  assert_bad_reads_zero_R13: assert property (@(posedge clk) disable iff (rst)
    illegal |-> rdData == '0);

  assert_idle_zero_R13: assert property (@(posedge clk) disable iff (rst)
    !rdEn |-> rdData == '0);

endmodule

// File: tb/csr_ctr_file_tb.sv
module csr_ctr_file_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CBASE = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rdEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [5:0]  csrIdx = '0;
  logic [63:0] wrData = '0;
  logic [63:0] timeIn = 64'h0123_4567_89AB_CDEF;
  logic        retire = 1'b0;
  logic [63:0] rdData;
  logic        illegal;

  int nChk = 0;
  int nFail = 0;
  logic [63:0] expCyc;
  logic [63:0] expInst;
  logic [63:0] shadow [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  csr_ctr_file dut_i (
    .clk(clk), .rst(rst), .rdEn(rdEn), .wrEn(wrEn), .csrIdx(csrIdx),
    .wrData(wrData), .timeIn(timeIn), .retire(retire),
    .rdData(rdData), .illegal(illegal)
  );

  // reference counts, from R9 and R11
  always @(posedge clk) begin
    if (rst) begin
      expCyc  <= '0;
      expInst <= '0;
    end else begin
      expCyc <= expCyc + 64'd1;
      if (retire) expInst <= expInst + 64'd1;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%016h expected 0x%016h", req, act, exp);
    end
  endtask

  task automatic rd(input int idx, output logic [63:0] d, output logic bad);
    @(negedge clk);
    rdEn = 1'b1;
    csrIdx = 6'(idx);
    #1;
    d = rdData;
    bad = illegal;
    rdEn = 1'b0;
  endtask

  task automatic wr(input int idx, input logic [63:0] d, output logic bad);
    @(negedge clk);
    wrEn = 1'b1;
    csrIdx = 6'(idx);
    wrData = d;
    #1;
    bad = illegal;
    @(posedge clk);
    #1;
    wrEn = 1'b0;
  endtask

  function automatic logic [63:0] ctrExp(input int n);
    if (n == 1) return timeIn;
    if (n == 2) return expInst;
    return expCyc;
  endfunction

  task automatic checkShadow(input string req);
    logic [63:0] d;
    logic b;
    for (int i = 0; i < 8; i++) begin
      rd(i, d, b);
      chk(req, d, shadow[i]);
    end
  endtask

  task automatic t_reset();
    logic [63:0] d;
    logic b;
    rd(0, d, b); chk("R1 priv", d, 64'd3);
    rd(2, d, b); chk("R1 vendor", d, 64'd0);
    rd(3, d, b); chk("R1 arch", d, 64'd0);
    rd(4, d, b); chk("R1 impl", d, 64'd0);
    rd(1, d, b); chk("R2 isa", d, 64'h8000_0000_0014_112D);
    rd(5, d, b); chk("R3 status", d, 64'h0000_000A_0000_2000);
    rd(6, d, b); chk("R4 mcen", d, 64'h7);
    rd(7, d, b); chk("R4 scen", d, 64'h7);
    @(negedge clk); csrIdx = 6'd1; #1;
    chk("R13 idle read zero", rdData, 64'd0);
    shadow[0] = 64'd3; shadow[1] = 64'h8000_0000_0014_112D;
    shadow[2] = 0; shadow[3] = 0; shadow[4] = 0;
    shadow[5] = 64'h0000_000A_0000_2000; shadow[6] = 64'h7; shadow[7] = 64'h7;
  endtask

  task automatic t_plain_write();
    logic [63:0] d;
    logic b;
    wr(2, 64'hDEAD_BEEF_0BAD_F00D, b); shadow[2] = 64'hDEAD_BEEF_0BAD_F00D;
    rd(2, d, b); chk("R5 vendor readback", d, shadow[2]);
    wr(5, 64'hFFFF_FFFF_FFFF_FFFF, b); shadow[5] = '1;
    rd(5, d, b); chk("R5 status readback", d, shadow[5]);
    wr(4, 64'h0000_0001_0000_0000, b); shadow[4] = 64'h0000_0001_0000_0000;
    checkShadow("R5 all plain");
  endtask

  task automatic t_machine_ctr();
    logic [63:0] d;
    logic b;
    for (int n = 0; n < 32; n++) begin
      rd(CBASE + n, d, b);
      chk((n == 1) ? "R10 time" : "R6 R9 machine counter", d, ctrExp(n));
    end
    timeIn = 64'hFEDC_BA98_7654_3210;
    rd(CBASE + 1, d, b); chk("R10 time change", d, 64'hFEDC_BA98_7654_3210);
  endtask

  task automatic t_retire();
    logic [63:0] d;
    logic b;
    @(negedge clk); retire = 1'b1;
    repeat (5) @(negedge clk);
    retire = 1'b0;
    repeat (3) @(negedge clk);
    retire = 1'b1;
    @(negedge clk); retire = 1'b0;
    rd(CBASE + 2, d, b); chk("R11 instret count", d, 64'd6);
    rd(CBASE + 2, d, b); chk("R11 instret holds", d, 64'd6);
  endtask

  task automatic t_gating();
    logic [63:0] d;
    logic b;
    logic [63:0] mMask;
    logic [63:0] sMask;
    mMask = 64'h0000_0000_8000_0005;
    sMask = 64'h0000_0000_0000_4002;
    wr(6, mMask, b); shadow[6] = mMask;
    wr(7, sMask, b); shadow[7] = sMask;
    wr(0, 64'd1, b); shadow[0] = 64'd1;
    for (int n = 0; n < 32; n++) begin
      rd(CBASE + n, d, b);
      chk("R7 supervisor gate", d, mMask[n] ? ctrExp(n) : 64'd0);
      if (!mMask[n]) chk("R8 no illegal when gated", 64'(b), 64'd0);
    end
    wr(0, 64'd0, b); shadow[0] = 64'd0;
    for (int n = 0; n < 32; n++) begin
      rd(CBASE + n, d, b);
      chk("R7 user gate", d, sMask[n] ? ctrExp(n) : 64'd0);
    end
    wr(0, 64'd2, b); shadow[0] = 64'd2;
    for (int n = 0; n < 4; n++) begin
      rd(CBASE + n, d, b);
      chk("R7 reserved level", d, 64'd0);
    end
    wr(0, 64'd3, b); shadow[0] = 64'd3;
    rd(CBASE + 0, d, b); chk("R6 machine again", d, expCyc);
  endtask

  task automatic t_ctr_write();
    logic [63:0] d;
    logic b;
    wr(CBASE + 0, 64'd0, b);
    wr(CBASE + 2, 64'h1234, b);
    wr(CBASE + 31, 64'hFFFF, b);
    chk("R12 counter write not illegal", 64'(b), 64'd0);
    checkShadow("R12 plain untouched");
    rd(CBASE + 0, d, b); chk("R12 cycle undisturbed", d, expCyc);
    rd(CBASE + 2, d, b); chk("R12 instret undisturbed", d, expInst);
    rd(CBASE + 17, d, b); chk("R9 hpm mirrors cycle", d, expCyc);
  endtask

  task automatic t_illegal();
    logic [63:0] d;
    logic b;
    rd(8, d, b);
    chk("R13 illegal flag idx 8", 64'(b), 64'd1);
    chk("R13 illegal read zero", d, 64'd0);
    rd(31, d, b);
    chk("R13 illegal flag idx 31", 64'(b), 64'd1);
    wr(20, 64'hAAAA_5555_AAAA_5555, b);
    chk("R13 illegal on write", 64'(b), 64'd1);
    checkShadow("R13 write discarded");
    rd(7, d, b);
    chk("R13 valid not illegal", 64'(b), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_plain_write();
    t_machine_ctr();
    t_retire();
    t_gating();
    t_ctr_write();
    t_illegal();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule